// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This block moves received Ethernet frames from a byte stream into system memory. Software places a ring of four-word descriptors in memory. Each descriptor holds a buffer address, a control word and a link to the next descriptor, and the last link points back to the first. Software marks a descriptor as free by setting the top bit of its control word and giving the buffer capacity in the low twelve bits. The engine waits for the first byte of a frame, then reads the current descriptor. If the descriptor is free, the engine packs the frame bytes into little-endian words and writes them to the buffer. When the frame ends, it writes the length back into the control word, clears the free bit and moves on to the linked descriptor.

If the current descriptor is still owned by software, the incoming frame is discarded and an overflow flag is raised. The same descriptor is read again when the next frame begins. A memory access that returns an error raises a bus-error flag, and the rest of that frame is discarded. A small register file holds the enable bit, the ring pointer, a saturating count of frames not yet serviced, the error flags, and an interrupt enable mask that drives a single interrupt line.

Top module: `rxd_ring_dma`

## Requirements
- R1: While reset is held and after it is released, s_ready and irq are low, no memory request is issued, and the status register (index 2) reads zero.
- R2: With control register (index 0) bit 0 clear, an idle engine keeps s_ready low and issues no memory request, whatever the stream presents.
- R3: At the first byte of a frame, the engine reads the descriptor's control word at pointer+4. Bit 31 set means the buffer is free, and bits 11:0 give its capacity. The engine then reads the buffer address at pointer+0 and the next pointer at pointer+8.
- R4: Frame byte k is written to buffer address+k, packed little-endian into 32-bit words. Only the lanes that hold frame bytes are enabled, so buffer bytes past the frame end keep their old value.
- R5: At frame end, the control word at pointer+4 is rewritten with the byte count in bits 11:0 and all other bits zero, which clears the free bit. The count includes the trailing 4 CRC bytes, because every byte of the stream is counted.
- R6: Bytes beyond the buffer capacity are not written, and the stored length is then the capacity.
- R7: After a writeback, the ring pointer (register index 1) takes the next-pointer value that was read. Following the links wraps around the ring.
- R8: Each written-back frame adds one to the count in status bits 23:16, which saturates at 255. Status bit 0 reads 1 while the count is nonzero. Writing 1 to status bit 0 subtracts one from the count.
- R9: When the control word read has bit 31 clear, the whole frame is consumed without any memory write, status bit 2 (overflow) is set, and the pointer does not move. The same descriptor is read again for the next frame.
- R10: An error on any memory access sets status bit 3 (bus error). The remainder of the frame is discarded, and the descriptor is neither written back nor advanced.
- R11: Writing 1 to status bit 2 or bit 3 clears that flag. Writing 0 leaves it unchanged.
- R12: Interrupt status (index 4) shows a nonzero count in bit 4, overflow in bit 6 and bus error in bit 7. irq is the OR of those bits masked by the interrupt enable register (index 3).
- R13: A memory request stays asserted, with a stable address, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Frames are sent in four patterns, and each one separates a different fault. The first is short frames that end part-way through a word, which exposes lane-enable and length errors. The second is a frame longer than its buffer, which tells truncation apart from a plain length count. The third is a frame that arrives when the ring has wrapped onto a descriptor still owned by software, which shows whether the engine drops the frame or overwrites a busy buffer. The fourth is a frame whose buffer write fails, which shows whether the descriptor is wrongly advanced or written back. A behavioural model keeps an expected memory image, pointer and status, and these are compared with the design after every frame and every register write. The disable, masking and write-one-to-clear paths are each exercised on their own.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 16;
  localparam logic [31:0] FREE_BIT = 32'h8000_0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_CTL, ST_RD_BUF, ST_RD_NXT, ST_RECV, ST_WR, ST_WB, ST_DROP
  } eng_state_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_PTR  = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_IEN  = 3'd3;
  localparam logic [2:0] RA_ISR  = 3'd4;

  function automatic logic [LEN_W-1:0] stored_len(input logic [CNT_W-1:0] got,
                                                   input logic [LEN_W-1:0] cap);
    if (got > CNT_W'(cap)) return cap;
    return got[LEN_W-1:0];
  endfunction

  function automatic logic [31:0] wb_word(input logic [LEN_W-1:0] n);
    return {{(32-LEN_W){1'b0}}, n};
  endfunction

  function automatic logic [3:0] lane_bit(input logic [1:0] lane, input logic on);
    return on ? (4'b0001 << lane) : 4'b0000;
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[lane*8 +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          evt_pkt,
  input  logic          evt_ovf,
  input  logic          evt_berr,
  input  logic [AW-1:0] cur_ptr,
  output logic          en,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_val,
  output logic [CNT_BITS-1:0] pkt_cnt,
  output logic          irq
);
  localparam logic [CNT_BITS-1:0] CNT_MAX = '1;

  logic       ovf_q, berr_q;
  logic [7:0] ien_q;
  logic       wr_stat, cnt_inc, cnt_dec;
  logic [7:0] isr;

  assign wr_stat  = reg_we && (reg_addr == RA_STAT);
  assign cnt_inc  = evt_pkt && (pkt_cnt != CNT_MAX);
  assign cnt_dec  = wr_stat && reg_wdata[0] && (pkt_cnt != '0);
  assign ptr_load = reg_we && (reg_addr == RA_PTR);
  assign ptr_val  = reg_wdata[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      ien_q   <= '0;
      ovf_q   <= 1'b0;
      berr_q  <= 1'b0;
      pkt_cnt <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CTRL) en <= reg_wdata[0];
      if (reg_we && reg_addr == RA_IEN)  ien_q <= reg_wdata[7:0];
      ovf_q  <= (ovf_q  && !(wr_stat && reg_wdata[2])) || evt_ovf;
      berr_q <= (berr_q && !(wr_stat && reg_wdata[3])) || evt_berr;
      case ({cnt_inc, cnt_dec})
        2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
        2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
        default: pkt_cnt <= pkt_cnt;
      endcase
    end
  end

  always_comb begin
    isr    = '0;
    isr[4] = (pkt_cnt != '0);
    isr[6] = ovf_q;
    isr[7] = berr_q;
  end

  assign irq = |(isr & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata[0] = en;
      RA_PTR:  reg_rdata = 32'(cur_ptr);
      RA_STAT: begin
        reg_rdata[16 +: CNT_BITS] = pkt_cnt;
        reg_rdata[0] = (pkt_cnt != '0);
        reg_rdata[2] = ovf_q;
        reg_rdata[3] = berr_q;
      end
      RA_IEN:  reg_rdata[7:0] = ien_q;
      RA_ISR:  reg_rdata[7:0] = isr;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_val,
  output logic [AW-1:0] cur_ptr,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          evt_pkt,
  output logic          evt_ovf,
  output logic          evt_berr,
  output logic          wb_phase,
  output logic          idle
);
  localparam logic [AW-1:0] OFS_CTL = AW'(4);
  localparam logic [AW-1:0] OFS_NXT = AW'(8);

  eng_state_t st;
  logic [AW-1:0]    nxt_q, buf_q, wr_addr_q;
  logic [LEN_W-1:0] cap_q;
  logic [CNT_W-1:0] got_q;
  logic [31:0]      wbuf_q;
  logic [3:0]       be_q;
  logic             last_q;

  logic [1:0] lane;
  logic       in_room, take, word_end;
  logic [3:0] be_nx;
  logic       rd_ok, rd_bad;

  assign lane     = got_q[1:0];
  assign in_room  = got_q < CNT_W'(cap_q);
  assign s_ready  = (st == ST_RECV) || (st == ST_DROP);
  assign take     = s_valid && s_ready;
  assign word_end = (lane == 2'd3) || s_last;
  assign be_nx    = be_q | lane_bit(lane, in_room);
  assign rd_ok    = mem_ack && !mem_err;
  assign rd_bad   = mem_ack && mem_err;
  assign wb_phase = (st == ST_WB);
  assign idle     = (st == ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (st)
      ST_RD_CTL: begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_CTL; end
      ST_RD_BUF: begin mem_req = 1'b1; mem_addr = cur_ptr; end
      ST_RD_NXT: begin mem_req = 1'b1; mem_addr = cur_ptr + OFS_NXT; end
      ST_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = wr_addr_q; mem_wdata = wbuf_q; mem_be = be_q;
      end
      ST_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur_ptr + OFS_CTL;
        mem_wdata = wb_word(stored_len(got_q, cap_q));
      end
      default: ;
    endcase
  end

  always_comb begin
    evt_pkt  = 1'b0;
    evt_ovf  = 1'b0;
    evt_berr = mem_req && rd_bad;
    if (st == ST_WB && rd_ok) evt_pkt = 1'b1;
    if (st == ST_RD_CTL && rd_ok && !mem_rdata[31]) evt_ovf = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_ptr   <= '0;
      nxt_q     <= '0;
      buf_q     <= '0;
      wr_addr_q <= '0;
      cap_q     <= '0;
      got_q     <= '0;
      wbuf_q    <= '0;
      be_q      <= '0;
      last_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (en && s_valid) st <= ST_RD_CTL;
        ST_RD_CTL: if (mem_ack) begin
          if (mem_err || !mem_rdata[31]) st <= ST_DROP;
          else begin
            cap_q <= mem_rdata[LEN_W-1:0];
            got_q <= '0;
            be_q  <= '0;
            st    <= ST_RD_BUF;
          end
        end
        ST_RD_BUF: if (mem_ack) begin
          buf_q <= mem_rdata[AW-1:0];
          st    <= mem_err ? ST_DROP : ST_RD_NXT;
        end
        ST_RD_NXT: if (mem_ack) begin
          nxt_q <= mem_rdata[AW-1:0];
          st    <= mem_err ? ST_DROP : ST_RECV;
        end
        ST_RECV: if (take) begin
          wbuf_q <= put_byte(wbuf_q, lane, s_data);
          be_q   <= be_nx;
          got_q  <= (got_q == '1) ? got_q : got_q + 1'b1;
          if (in_room) wr_addr_q <= buf_q + AW'({got_q[CNT_W-1:2], 2'b00});
          if (word_end) begin
            last_q <= s_last;
            if (be_nx != '0) st <= ST_WR;
            else if (s_last) st <= ST_WB;
          end
        end
        ST_WR: if (mem_ack) begin
          be_q <= '0;
          if (mem_err) st <= last_q ? ST_IDLE : ST_DROP;
          else         st <= last_q ? ST_WB : ST_RECV;
        end
        ST_WB: if (mem_ack) begin
          if (!mem_err) cur_ptr <= nxt_q;
          st <= ST_IDLE;
        end
        ST_DROP: if (take && s_last) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (ptr_load) cur_ptr <= ptr_val;
    end
  end
endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma #(
  parameter int AW = 32,
  parameter int CNT_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  logic          ctl_en, ptr_load, evt_pkt, evt_ovf, evt_berr, wb_phase, eng_idle;
  logic [AW-1:0] ptr_val, cur_ptr;
  logic [CNT_BITS-1:0] pkt_cnt;

  rxd_regs #(.AW(AW), .CNT_BITS(CNT_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pkt(evt_pkt), .evt_ovf(evt_ovf), .evt_berr(evt_berr),
    .cur_ptr(cur_ptr), .en(ctl_en), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .pkt_cnt(pkt_cnt), .irq(irq)
  );

  rxd_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(ctl_en),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .cur_ptr(cur_ptr),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .evt_pkt(evt_pkt), .evt_ovf(evt_ovf), .evt_berr(evt_berr),
    .wb_phase(wb_phase), .idle(eng_idle)
  );
endmodule

// File: rtl/rxd_ring_dma_chk.sv
module rxd_ring_dma_chk #(
  parameter int AW = 32,
  parameter int CNT_BITS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_rdata,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          ctl_en,
  input logic          eng_idle,
  input logic          evt_pkt,
  input logic          evt_ovf,
  input logic          evt_berr,
  input logic          wb_phase,
  input logic [CNT_BITS-1:0] pkt_cnt
);
  localparam logic [CNT_BITS-1:0] TOP = '1;

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && eng_idle) |=> (!s_ready && !mem_req));

  assert_wb_clears_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_phase && mem_req) |-> (mem_we && !mem_wdata[31] && mem_wdata[31:12] == '0));

  assert_write_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  assert_busy_desc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |-> (mem_ack && !mem_we && !mem_rdata[31]));

  assert_pkt_on_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pkt |-> (mem_ack && mem_we && !mem_err));

  assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pkt_cnt) == TOP && $past(rst_n)) |-> (pkt_cnt >= TOP - 1'b1));

  assert_berr_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_berr |-> (mem_ack && mem_err));
endmodule

bind rxd_ring_dma rxd_ring_dma_chk #(.AW(AW), .CNT_BITS(CNT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
  .ctl_en(ctl_en), .eng_idle(eng_idle), .evt_pkt(evt_pkt), .evt_ovf(evt_ovf),
  .evt_berr(evt_berr), .wb_phase(wb_phase), .pkt_cnt(pkt_cnt)
);

// File: tb/rxd_ring_dma_test.sv
module rxd_ring_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_mem [0:1023];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int   exp_ptr = 'h100, exp_cnt = 0;
  bit   exp_ovf = 0, exp_berr = 0;
  logic [7:0] exp_ien = 8'h00;

  always #5 clk = ~clk;

  rxd_ring_dma uut (.*);

  // memory: one-cycle acknowledge, writes honour byte lanes
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_addr == err_addr) mem_err <= 1'b1;
      else begin
        mem_err <= 1'b0;
        if (mem_we) begin
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[11:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
        end else mem_rdata <= mem[mem_addr[11:2]];
      end
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic send_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fbyte(seed, i); s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  // behavioural reference for one frame
  task automatic model_frame(input int n, input int seed, input bit fail_buf);
    logic [31:0] ctl;
    int b, cap, keep, a;
    ctl = exp_mem[(exp_ptr + 4) >> 2];
    if (!ctl[31]) begin exp_ovf = 1; return; end
    if (fail_buf) begin exp_berr = 1; return; end
    cap = int'(ctl[11:0]);
    b   = int'(exp_mem[exp_ptr >> 2]);
    keep = (n < cap) ? n : cap;
    for (int i = 0; i < keep; i++) begin
      a = b + i;
      exp_mem[a >> 2][(a & 3) * 8 +: 8] = fbyte(seed, i);
    end
    exp_mem[(exp_ptr + 4) >> 2] = 32'(keep);
    if (exp_cnt < 255) exp_cnt++;
    exp_ptr = int'(exp_mem[(exp_ptr + 8) >> 2]);
  endtask

  task automatic compare_all(input string req);
    logic [31:0] v, e;
    int bad = 0, first = -1;
    for (int w = 0; w < 1024; w++)
      if (mem[w] !== exp_mem[w]) begin bad++; if (first < 0) first = w; end
    chk(req, "memory image mismatching words", 32'(bad), 32'd0);
    if (first >= 0) chk(req, $sformatf("word at %h", first * 4), mem[first], exp_mem[first]);
    rd_reg(3'd2, v);
    e = '0; e[23:16] = 8'(exp_cnt); e[0] = (exp_cnt != 0); e[2] = exp_ovf; e[3] = exp_berr;
    chk(req, "status register", v, e);
    rd_reg(3'd1, v);
    chk(req, "ring pointer", v, 32'(exp_ptr));
    e = '0; e[4] = (exp_cnt != 0); e[6] = exp_ovf; e[7] = exp_berr;
    rd_reg(3'd4, v);
    chk(req, "interrupt status", v, e);
    chk(req, "irq line", 32'(irq), 32'(|(e[7:0] & exp_ien)));
  endtask

  task automatic set_desc(input int d, input int bufa, input int ctl, input int nxt);
    mem[d >> 2] = 32'(bufa); mem[(d >> 2) + 1] = 32'(ctl); mem[(d >> 2) + 2] = 32'(nxt);
    exp_mem[d >> 2] = 32'(bufa); exp_mem[(d >> 2) + 1] = 32'(ctl); exp_mem[(d >> 2) + 2] = 32'(nxt);
  endtask

  initial begin
    logic [31:0] v;
    int hits;
    for (int w = 0; w < 1024; w++) begin mem[w] = 32'hEEEE_EEEE; exp_mem[w] = 32'hEEEE_EEEE; end
    set_desc('h100, 'h200, 'h8000_0040, 'h110);
    set_desc('h110, 'h300, 'h8000_0040, 'h120);
    set_desc('h120, 'h400, 'h8000_0008, 'h100);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "s_ready in reset", 32'(s_ready), 0);
    chk("R1", "mem_req in reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    rd_reg(3'd2, v);
    chk("R1", "status after reset", v, 0);
    chk("R1", "irq after reset", 32'(irq), 0);

    // R2 disabled engine ignores stream
    @(negedge clk); s_valid = 1'b1; s_data = 8'h5A;
    hits = 0;
    repeat (20) begin @(negedge clk); if (s_ready || mem_req) hits++; end
    s_valid = 1'b0;
    chk("R2", "accepts or accesses while disabled", 32'(hits), 0);

    wr_reg(3'd1, 32'h100);
    wr_reg(3'd3, 32'hD0); exp_ien = 8'hD0;
    wr_reg(3'd0, 32'h1);

    // R3 R4 R5 short frame ending mid-word
    send_frame(10, 3); model_frame(10, 3, 0);
    compare_all("R3/R4/R5 frame of 10");
    // R7 advance, odd length
    send_frame(17, 40); model_frame(17, 40, 0);
    compare_all("R7/R4 frame of 17");
    // R6 truncation to capacity 8
    send_frame(20, 90); model_frame(20, 90, 0);
    compare_all("R6 frame truncated");
    chk("R6", "stored length", mem['h124 >> 2], 32'd8);
    // R9 ring wrapped onto busy descriptor
    send_frame(12, 7); model_frame(12, 7, 0);
    compare_all("R9 busy descriptor");
    chk("R8", "count after three frames", 32'(exp_cnt), 32'd3);
    // R8 write-one-to-clear count
    wr_reg(3'd2, 32'h1); exp_cnt--;
    compare_all("R8 decrement");
    wr_reg(3'd2, 32'h0);
    compare_all("R8 zero write keeps count");
    wr_reg(3'd2, 32'h1); exp_cnt--;
    wr_reg(3'd2, 32'h1); exp_cnt--;
    wr_reg(3'd2, 32'h1);
    compare_all("R8 count at zero");
    // R12 masking and R11 clearing
    wr_reg(3'd3, 32'h10); exp_ien = 8'h10;
    compare_all("R12 overflow masked");
    wr_reg(3'd3, 32'hD0); exp_ien = 8'hD0;
    wr_reg(3'd2, 32'h4); exp_ovf = 0;
    compare_all("R11 overflow cleared");
    // R9 same descriptor re-read once freed
    set_desc('h100, 'h200, 'h8000_0040, 'h110);
    send_frame(5, 200); model_frame(5, 200, 0);
    compare_all("R9 retry same descriptor");
    // R10 bus error on buffer write
    set_desc('h110, 'h300, 'h8000_0040, 'h120);
    err_addr = 32'h300;
    send_frame(6, 60); model_frame(6, 60, 1);
    compare_all("R10 bus error");
    err_addr = 32'hFFFF_FFFF;
    wr_reg(3'd2, 32'h8); exp_berr = 0;
    compare_all("R11 bus error cleared");
    send_frame(4, 11); model_frame(4, 11, 0);
    compare_all("R10 recovery frame");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule